// File: doc/BRIEF.md
# Teleprinter Character Mode Filter

This block sits between a console interface and its character streams. It conditions characters in two directions: keyboard characters travelling towards the processor, and printer characters travelling towards the terminal. Each character arrives as an 8-bit code with a one-cycle valid strobe. The filtered result leaves one clock later with its own strobe, or it does not leave at all.

A single mode register serves both directions, so a write to it changes the behaviour of both paths at once. The register selects one of three treatments:
- Upper-case folding: the code is cut to 7 bits and lower-case letters become capitals.
- 7-bit masking: the eighth bit is cleared.
- Transparent pass-through: the code is not changed.

The printer path has two more duties. In the two restrictive modes it drops control codes that a terminal would misinterpret. When automatic line feed is enabled, it also follows every emitted carriage return with a line feed.

The inserted line feed takes one output slot. During that slot the printer side lowers its ready signal, so no outgoing character is lost.

Top module: `tty_char_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to upper-case mode (`mode_o` = 2'b00) after that edge, with `kbd_out_valid` and `prn_out_valid` low and `prn_in_ready` high.
- R2: Mode codes are 2'b00 upper-case, 2'b01 7-bit and 2'b10 transparent. A write with `mode_wr_en` high takes effect from the next cycle, and a character accepted in the same cycle still uses the old mode. A write of code 2'b11 leaves the mode unchanged.
- R3: In upper-case mode, every character on either path is first reduced to its low 7 bits. If the result lies in 0x61..0x7A, bit 5 is then cleared.
- R4: In 7-bit mode, every character on either path leaves with bit 7 cleared and bits 6..0 unchanged.
- R5: In transparent mode, every character on either path leaves unchanged, and no printer character is dropped.
- R6: In upper-case and 7-bit modes, the printer path drops a character when its converted value is below 0x20 or equal to 0x7F. The exceptions are 0x07, 0x08, 0x09, 0x0A and 0x0D, which are kept. The keyboard path never drops a character.
- R7: A mode write changes the conversion on the keyboard path and the printer path in the same cycle.
- R8: When a printer character whose converted value is 0x0D is accepted while `autolf_en` is high, the output shows 0x0D in the next cycle and 0x0A in the cycle after. `autolf_en` is sampled only when the carriage return is accepted.
- R9: `prn_in_ready` is low for exactly the one cycle in which an inserted line feed is pending. A printer character offered in that cycle is not accepted and produces no output.
- R10: Every accepted character on either path appears at the output exactly one cycle after acceptance. Without an accepted character or a pending line feed, the output strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_en | input | 1 | Mode register write strobe |
| mode_wr_code | input | 2 | New mode code |
| mode_o | output | 2 | Current mode code |
| autolf_en | input | 1 | Insert a line feed after each emitted carriage return |
| kbd_in_valid | input | 1 | Keyboard character strobe |
| kbd_in_data | input | 8 | Keyboard character |
| kbd_out_valid | output | 1 | Filtered keyboard character strobe |
| kbd_out_data | output | 8 | Filtered keyboard character |
| prn_in_valid | input | 1 | Printer character strobe |
| prn_in_data | input | 8 | Printer character |
| prn_in_ready | output | 1 | Printer path can accept a character |
| prn_out_valid | output | 1 | Filtered printer character strobe |
| prn_out_data | output | 8 | Filtered printer character |

## Verification
The hardest situation to reach from the ports is a printer character offered in the single stalled cycle after a carriage return. It becomes harder still when that carriage return is a masked 0x8D, or when `autolf_en` or the mode changes during the stall.

The stimulus gets there by holding `prn_in_valid` high across runs of back-to-back carriage returns in every mode. It also lowers `autolf_en` and writes a new mode exactly in the stalled cycle. A long pseudo-random stream then mixes mode writes, illegal mode codes and dense carriage returns. Exhaustive sweeps of all 256 codes in each mode cover the conversion and suppression tables on both paths.

// File: rtl/tty_filt_pkg.sv
package tty_filt_pkg;

    localparam int CHAR_W = 8;
    localparam int MODE_W = 2;
    localparam int KEEP_N = 5;

    localparam logic [CHAR_W-1:0] CR_CODE  = 8'h0D;
    localparam logic [CHAR_W-1:0] LF_CODE  = 8'h0A;
    localparam logic [CHAR_W-1:0] DEL_CODE = 8'h7F;
    localparam logic [CHAR_W-1:0] SPACE    = 8'h20;
    localparam logic [CHAR_W-1:0] LC_FIRST = 8'h61;
    localparam logic [CHAR_W-1:0] LC_LAST  = 8'h7A;
    localparam int                CASE_BIT = 5;

    // control codes that survive the restrictive modes on output
    localparam logic [CHAR_W-1:0] KEEP_CODES [KEEP_N] =
        '{8'h07, 8'h08, 8'h09, 8'h0A, 8'h0D};

    typedef enum logic [MODE_W-1:0] {
        MODE_UC = 2'b00,
        MODE_7B = 2'b01,
        MODE_8B = 2'b10
    } tty_mode_e;

    typedef struct packed {
        logic              vld;
        logic [CHAR_W-1:0] ch;
    } tty_char_t;

    function automatic logic mode_code_ok(input logic [MODE_W-1:0] code);
        return (code == MODE_UC) || (code == MODE_7B) || (code == MODE_8B);
    endfunction

    function automatic logic [CHAR_W-1:0] char_xform(input logic [CHAR_W-1:0] c,
                                                     input tty_mode_e m);
        logic [CHAR_W-1:0] r;
        r = (m == MODE_8B) ? c : {1'b0, c[CHAR_W-2:0]};
        if ((m == MODE_UC) && (r >= LC_FIRST) && (r <= LC_LAST))
            r[CASE_BIT] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/tty_mode_reg.sv
module tty_mode_reg
    import tty_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_code,
    output tty_mode_e         mode_o
);
    tty_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_UC;
        else if (wr_en && mode_code_ok(wr_code))
            mode_q <= tty_mode_e'(wr_code);
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/tty_char_xform.sv
module tty_char_xform
    import tty_filt_pkg::*;
#(
    parameter bit FILTER_CTRL = 1'b1
) (
    input  tty_char_t in_i,
    input  tty_mode_e mode_i,
    output tty_char_t out_o
);
    logic [CHAR_W-1:0] conv;

    assign conv     = char_xform(in_i.ch, mode_i);
    assign out_o.ch = conv;

    generate
        if (FILTER_CTRL) begin : g_filt
            logic [KEEP_N-1:0] hit;
            logic              is_ctrl;
            for (genvar i = 0; i < KEEP_N; i++) begin : g_keep
                assign hit[i] = (conv == KEEP_CODES[i]);
            end
            assign is_ctrl   = (conv < SPACE) || (conv == DEL_CODE);
            assign out_o.vld = in_i.vld &&
                               ((mode_i == MODE_8B) || !is_ctrl || (|hit));
        end else begin : g_pass
            assign out_o.vld = in_i.vld;
        end
    endgenerate
endmodule

// File: rtl/tty_kbd_stage.sv
module tty_kbd_stage
    import tty_filt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tty_char_t in_i,
    output tty_char_t out_o
);
    tty_char_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q.vld <= 1'b0;
            q.ch  <= '0;
        end else begin
            q.vld <= in_i.vld;
            if (in_i.vld)
                q.ch <= in_i.ch;
        end
    end

    assign out_o = q;
endmodule

// File: rtl/tty_prn_seq.sv
module tty_prn_seq
    import tty_filt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tty_char_t in_i,
    input  logic      autolf_i,
    output logic      ready_o,
    output tty_char_t out_o
);
    tty_char_t q;
    logic      lf_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q.vld     <= 1'b0;
            q.ch      <= '0;
            lf_pend_q <= 1'b0;
        end else if (lf_pend_q) begin
            q.vld     <= 1'b1;
            q.ch      <= LF_CODE;
            lf_pend_q <= 1'b0;
        end else begin
            q.vld     <= in_i.vld;
            if (in_i.vld)
                q.ch  <= in_i.ch;
            lf_pend_q <= in_i.vld && autolf_i && (in_i.ch == CR_CODE);
        end
    end

    assign ready_o = !lf_pend_q;
    assign out_o   = q;
endmodule

// File: rtl/tty_char_filter.sv
module tty_char_filter
    import tty_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr_en,
    input  logic [MODE_W-1:0] mode_wr_code,
    output logic [MODE_W-1:0] mode_o,
    input  logic              autolf_en,
    input  logic              kbd_in_valid,
    input  logic [CHAR_W-1:0] kbd_in_data,
    output logic              kbd_out_valid,
    output logic [CHAR_W-1:0] kbd_out_data,
    input  logic              prn_in_valid,
    input  logic [CHAR_W-1:0] prn_in_data,
    output logic              prn_in_ready,
    output logic              prn_out_valid,
    output logic [CHAR_W-1:0] prn_out_data
);
    tty_mode_e mode;
    tty_char_t kbd_raw, kbd_conv, kbd_q;
    tty_char_t prn_raw, prn_conv, prn_q;
    logic      prn_rdy;

    tty_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mode_wr_en),
        .wr_code (mode_wr_code),
        .mode_o  (mode)
    );

    assign kbd_raw.vld = kbd_in_valid;
    assign kbd_raw.ch  = kbd_in_data;

    tty_char_xform #(.FILTER_CTRL(1'b0)) u_kbd_xf (
        .in_i   (kbd_raw),
        .mode_i (mode),
        .out_o  (kbd_conv)
    );

    tty_kbd_stage u_kbd (
        .clk   (clk),
        .rst   (rst),
        .in_i  (kbd_conv),
        .out_o (kbd_q)
    );

    assign prn_raw.vld = prn_in_valid && prn_rdy;
    assign prn_raw.ch  = prn_in_data;

    tty_char_xform #(.FILTER_CTRL(1'b1)) u_prn_xf (
        .in_i   (prn_raw),
        .mode_i (mode),
        .out_o  (prn_conv)
    );

    tty_prn_seq u_prn (
        .clk      (clk),
        .rst      (rst),
        .in_i     (prn_conv),
        .autolf_i (autolf_en),
        .ready_o  (prn_rdy),
        .out_o    (prn_q)
    );

    assign mode_o        = mode;
    assign kbd_out_valid = kbd_q.vld;
    assign kbd_out_data  = kbd_q.ch;
    assign prn_in_ready  = prn_rdy;
    assign prn_out_valid = prn_q.vld;
    assign prn_out_data  = prn_q.ch;
endmodule

// File: rtl/tty_char_filter_chk.sv
module tty_char_filter_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_wr_en,
    input logic [1:0] mode_wr_code,
    input logic [1:0] mode_o,
    input logic       autolf_en,
    input logic       kbd_in_valid,
    input logic [7:0] kbd_in_data,
    input logic       kbd_out_valid,
    input logic [7:0] kbd_out_data,
    input logic       prn_in_valid,
    input logic [7:0] prn_in_data,
    input logic       prn_in_ready,
    input logic       prn_out_valid,
    input logic [7:0] prn_out_data
);
    localparam logic [1:0] M_UC = 2'b00;
    localparam logic [1:0] M_8B = 2'b10;

    // R1
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (mode_o == M_UC) && !kbd_out_valid && !prn_out_valid && prn_in_ready);

    p_mode_legal_r2: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'b11);

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!mode_wr_en || mode_wr_code == 2'b11) |=> $stable(mode_o));

    p_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (kbd_in_valid && mode_o != M_8B) |=> !kbd_out_data[7]);

    p_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (kbd_in_valid && mode_o == M_8B) |=> kbd_out_data == $past(kbd_in_data));

    p_ctrl_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (prn_in_valid && prn_in_ready && mode_o != M_8B &&
         (prn_in_data[6:0] == 7'h1B || prn_in_data[6:0] == 7'h7F))
        |=> !prn_out_valid);

    p_cr_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (prn_in_valid && prn_in_ready && autolf_en && prn_in_data[6:0] == 7'h0D &&
         (mode_o != M_8B || !prn_in_data[7])) |=> !prn_in_ready);

    p_lf_out_r8: assert property (@(posedge clk) disable iff (rst)
        !prn_in_ready |=> prn_out_valid && prn_out_data == 8'h0A);

    p_stall_one_r9: assert property (@(posedge clk) disable iff (rst)
        !prn_in_ready |=> prn_in_ready);

    p_kbd_latency_r10: assert property (@(posedge clk) disable iff (rst)
        kbd_in_valid |=> kbd_out_valid);

    p_kbd_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !kbd_in_valid |=> !kbd_out_valid);

    p_prn_source_r10: assert property (@(posedge clk) disable iff (rst)
        (prn_in_ready && !prn_in_valid) |=> !prn_out_valid);
endmodule

bind tty_char_filter tty_char_filter_chk chk_i (.*);

// File: tb/tty_char_filter_tb_top.sv
`timescale 1ns/1ps
module tty_char_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       mode_wr_en;
    logic [1:0] mode_wr_code;
    logic [1:0] mode_o;
    logic       autolf_en;
    logic       kbd_in_valid;
    logic [7:0] kbd_in_data;
    logic       kbd_out_valid;
    logic [7:0] kbd_out_data;
    logic       prn_in_valid;
    logic [7:0] prn_in_data;
    logic       prn_in_ready;
    logic       prn_out_valid;
    logic [7:0] prn_out_data;

    always #2.5 clk = ~clk;

    tty_char_filter dut_i (.*);

    int    vectors = 0;
    int    errors  = 0;
    bit    done    = 0;
    string ovr     = "";

    // reference state
    int m_mode = 0, m_kmode = 0, m_pmode = 0;
    bit m_kv = 0, m_pv = 0, m_lf = 0, m_lf_out = 0, m_rst = 0;
    int m_kd = 0, m_pd = 0;

    function automatic int bx(int c, int md);
        int r = c;
        if (md != 2) r = r % 128;
        if (md == 0 && r >= 97 && r <= 122) r = r - 32;
        return r;
    endfunction

    function automatic bit keep(int c, int md);
        if (md == 2) return 1;
        if (c == 7 || c == 8 || c == 9 || c == 10 || c == 13) return 1;
        return (c >= 32 && c != 127);
    endfunction

    function automatic string mtag(int md);
        if (md == 0) return "R3";
        if (md == 1) return "R4";
        return "R5";
    endfunction

    task automatic chk(string tag, int act, int exp);
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        int  n_mode, n_kd, n_pd, c;
        bit  n_kv, n_pv, n_lf, n_lfo;
        int  n_km, n_pm;
        n_mode = m_mode; n_kd = m_kd; n_pd = m_pd; n_km = m_kmode; n_pm = m_pmode;
        n_kv = 0; n_pv = 0; n_lf = 0; n_lfo = 0;
        if (!rst) begin
            if (mode_wr_en && mode_wr_code != 2'b11) n_mode = int'(mode_wr_code);
            n_kv = kbd_in_valid;
            if (kbd_in_valid) begin n_kd = bx(int'(kbd_in_data), m_mode); n_km = m_mode; end
            if (m_lf) begin
                n_pv = 1; n_pd = 10; n_lfo = 1;
            end else if (prn_in_valid) begin
                c = bx(int'(prn_in_data), m_mode);
                n_pm = m_mode;
                if (keep(c, m_mode)) begin
                    n_pv = 1; n_pd = c;
                    n_lf = (c == 13) && autolf_en;
                end
            end
        end else begin
            n_mode = 0;
        end
        m_rst = rst;
        @(posedge clk);
        @(negedge clk);
        m_mode = n_mode; m_kv = n_kv; m_kd = n_kd; m_pv = n_pv; m_pd = n_pd;
        m_lf = n_lf; m_lf_out = n_lfo; m_kmode = n_km; m_pmode = n_pm;
        vectors++;
        if (m_rst) begin
            chk("R1 mode", int'(mode_o), 0);
            chk("R1 kbd_out_valid", int'(kbd_out_valid), 0);
            chk("R1 prn_out_valid", int'(prn_out_valid), 0);
            chk("R1 prn_in_ready", int'(prn_in_ready), 1);
        end else begin
            chk("R2/R7 mode", int'(mode_o), m_mode);
            chk("R9 prn_in_ready", int'(prn_in_ready), m_lf ? 0 : 1);
            chk("R10 kbd_out_valid", int'(kbd_out_valid), int'(m_kv));
            if (m_kv)
                chk(ovr != "" ? ovr : mtag(m_kmode), int'(kbd_out_data), m_kd);
            chk(m_pv ? "R10 prn_out_valid" : "R6 prn_out_valid", int'(prn_out_valid), int'(m_pv));
            if (m_pv && prn_out_valid)
                chk(m_lf_out ? "R8" : (ovr != "" ? ovr : mtag(m_pmode)),
                    int'(prn_out_data), m_pd);
        end
    endtask

    task automatic idle();
        mode_wr_en = 0; kbd_in_valid = 0; prn_in_valid = 0;
    endtask

    task automatic set_mode(int md);
        idle();
        mode_wr_en = 1; mode_wr_code = 2'(md);
        step();
        mode_wr_en = 0;
    endtask

    // offer a printer char, holding it until accepted
    task automatic send_prn(int c);
        bit acc;
        prn_in_valid = 1; prn_in_data = 8'(c);
        do begin
            acc = !m_lf;
            step();
        end while (!acc);
        prn_in_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        rst = 1; idle(); mode_wr_code = 0; autolf_en = 0;
        kbd_in_data = 0; prn_in_data = 0;
        // R1: reset state
        step(); step();
        rst = 0;
        step();

        // R2: illegal code ignored, then legal codes
        set_mode(3); step();
        set_mode(1); set_mode(3); step();

        // R3 R4 R5 R6: exhaustive sweeps on both paths
        for (int md = 0; md < 3; md++) begin
            set_mode(md);
            for (int c = 0; c < 256; c++) begin
                kbd_in_valid = 1; kbd_in_data = 8'(c);
                prn_in_valid = 1; prn_in_data = 8'((c * 37 + 11) % 256);
                step();
            end
            idle(); step();
        end

        // R8 R9: auto line feed with back-to-back CRs, valid held during stalls
        autolf_en = 1;
        for (int md = 0; md < 3; md++) begin
            set_mode(md);
            send_prn(8'h41); send_prn(8'h0D); send_prn(8'h62);
            send_prn(8'h8D); send_prn(8'h1B); send_prn(8'h0D);
            send_prn(8'h0D); send_prn(8'h63); step();
        end

        // R8: autolf dropped in the stall cycle still emits the LF
        set_mode(0);
        prn_in_valid = 1; prn_in_data = 8'h0D; step();
        autolf_en = 0; prn_in_data = 8'h44; step();
        step(); prn_in_valid = 0; step();
        autolf_en = 1;

        // R7: mode write alongside characters on both paths
        ovr = "R7";
        kbd_in_valid = 1; kbd_in_data = 8'hE1; prn_in_valid = 1; prn_in_data = 8'hF2;
        mode_wr_en = 1; mode_wr_code = 2'b10; step();
        mode_wr_en = 0; step();
        mode_wr_en = 1; mode_wr_code = 2'b01; step();
        mode_wr_en = 0; step();
        idle(); step();
        ovr = "";

        // mixed pseudo-random stream
        seed = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            seed = seed * 1103515245 + 12345;
            kbd_in_valid = seed[20];
            kbd_in_data  = seed[29:22];
            prn_in_valid = seed[21];
            prn_in_data  = (seed[19:17] == 0) ? 8'h0D : seed[16:9];
            mode_wr_en   = (seed[8:5] == 0);
            mode_wr_code = seed[4:3];
            autolf_en    = seed[2] | seed[1];
            step();
        end
        idle(); step(); step();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule